// File: doc/BRIEF.md
# Bidirectional Dual-Port Bus Register

This block is a word register placed between two bidirectional parallel buses, called port A and port B, with an additional serial input. Four control inputs pick what it does: an A-port enable that can lock port A out entirely, a direction control that names which port is the source and which is driven, a parallel/serial selector, and a clocked/clock-independent selector for parallel transfers. With these it can pass a word from one bus to the other, capture a word from either bus, keep (recirculate) its stored word, or assemble a word from the serial input and present it on either bus.

Each port is modelled as three vectors: an input vector seen from the bus, an output vector, and a per-bit output enable. The surrounding logic builds the tri-state pad or bus multiplexer from them. An output vector reads all zeros whenever its enables are off. The clock-independent parallel mode is built without latches. The driven port follows the selected source combinationally, and the register samples that source on every clock, so the word is kept after the controls change. The most significant register bit is also provided as a serial output for chaining.

Top module: `bidir_bus_reg`

## Requirements
- R1: An active-low synchronous reset (rst_n) clears every register bit to 0 on the clock edge where it is sampled low.
- R2: While a_en is 0, a_oe is all zeros and a_out is all zeros, and a_in has no effect on the stored word or on any output.
- R3: When dir_ab is 1, b_oe is all ones and a_oe is all zeros. When dir_ab is 0, b_oe is all zeros and a_oe equals a_en replicated across all bits. This holds in both serial and parallel modes.
- R4: When par_mode is 0 (serial), each rising edge shifts the word one position toward the most significant bit and places ser_in at bit 0. ser_out always equals bit 7 (the most significant bit) of the stored word. async_mode has no effect in this mode, and the driven port changes only at clock edges.
- R5: When par_mode is 1, async_mode is 0 and dir_ab is 0, the word on b_in is stored at the rising edge, and from then on it appears on a_out if a_en is 1.
- R6: When par_mode is 1, async_mode is 0, a_en is 1 and dir_ab is 1, the word on a_in is stored at the rising edge and then appears on b_out.
- R7: When par_mode is 1, a_en is 0 and dir_ab is 1, the stored word is recirculated: it is unchanged by clock edges and is shown on b_out, whatever the value of async_mode.
- R8: When par_mode is 1 and async_mode is 1, the driven port follows the selected source input (a_in when a_en and dir_ab are both 1, b_in when dir_ab is 0) without waiting for a clock edge. The register samples that source on every rising edge, so the last value seen at an edge is kept after leaving the mode.
- R9: In serial mode and in clocked parallel mode, the driven port shows the stored word. An undriven output vector reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_en | input | 1 | Port A enable; 0 locks port A out in both directions |
| dir_ab | input | 1 | 1: A is source and B is driven; 0: B is source and A is driven |
| par_mode | input | 1 | 1: parallel transfer; 0: serial shift |
| async_mode | input | 1 | In parallel mode, 1 makes transfers clock-independent |
| ser_in | input | 1 | Serial data entering at bit 0 |
| a_in | input | W | Port A bus value seen by the block |
| a_out | output | W | Port A value to drive, zero when not driven |
| a_oe | output | W | Port A per-bit output enable |
| b_in | input | W | Port B bus value seen by the block |
| b_out | output | W | Port B value to drive, zero when not driven |
| b_oe | output | W | Port B per-bit output enable |
| ser_out | output | 1 | Most significant stored bit |

## Verification
The parallel transfers are tried in both directions with distinct words (A5 from B, 3C from A), and each is read back both before and after the clock edge. This separates clocked capture from combinational pass-through. Recirculation is tried with port A held at all ones while locked out, so that any leak of a_in into the word shows up. A serial stream of mixed ones and zeros is shifted in with async_mode set, and the port is checked both at each edge and between edges, which catches a wrong shift direction or a mode that ignores the clock. In the clock-independent mode the source is changed between edges and the word is later read out in recirculation, which shows both the bypass path and the capture of the value present at the edge.

// File: rtl/bidir_bus_reg.sv
module bidir_bus_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_en,
  input  logic         dir_ab,
  input  logic         par_mode,
  input  logic         async_mode,
  input  logic         ser_in,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic         ser_out
);

  logic [W-1:0] q;
  logic [W-1:0] par_src;
  logic [W-1:0] nxt;
  logic [W-1:0] shown;
  logic         drive_a;
  logic         drive_b;
  logic         bypass;

  assign drive_a = a_en & ~dir_ab;
  assign drive_b = dir_ab;
  assign bypass  = par_mode & async_mode;

  always_comb begin
    if (dir_ab) par_src = a_en ? a_in : q;
    else        par_src = b_in;
  end

  assign nxt   = par_mode ? par_src : {q[W-2:0], ser_in};
  assign shown = bypass ? par_src : q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign a_oe    = {W{drive_a}};
  assign b_oe    = {W{drive_b}};
  assign a_out   = drive_a ? shown : '0;
  assign b_out   = drive_b ? shown : '0;
  assign ser_out = q[W-1];

endmodule

// File: rtl/bidir_bus_reg_chk.sv
module bidir_bus_reg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         a_en,
  input logic         dir_ab,
  input logic         par_mode,
  input logic         async_mode,
  input logic         ser_in,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic         ser_out,
  input logic [W-1:0] q
);

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> q == '0);

  a_r2_a_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |-> (a_oe == '0 && a_out == '0));

  a_r3_b_driven: assert property (@(posedge clk) disable iff (!rst_n)
    dir_ab |-> (b_oe == '1 && a_oe == '0));

  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !par_mode |=> q == {$past(q[W-2:0]), $past(ser_in)});

  a_r4_ser_out: assert property (@(posedge clk) disable iff (!rst_n)
    ser_out == q[W-1]);

  a_r5_load_b: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && !async_mode && !dir_ab) |=> q == $past(b_in));

  a_r6_load_a: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && !async_mode && a_en && dir_ab) |=> q == $past(a_in));

  a_r7_recirc: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && !a_en && dir_ab) |=> $stable(q));

  a_r8_follow_a: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && async_mode && a_en && dir_ab) |-> b_out == a_in);

  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && async_mode && a_en && dir_ab) |=> q == $past(a_in));

  a_r9_show_q: assert property (@(posedge clk) disable iff (!rst_n)
    (!(par_mode && async_mode) && dir_ab) |-> b_out == q);

endmodule

bind bidir_bus_reg bidir_bus_reg_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_en(a_en), .dir_ab(dir_ab),
  .par_mode(par_mode), .async_mode(async_mode), .ser_in(ser_in),
  .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in),
  .b_out(b_out), .b_oe(b_oe), .ser_out(ser_out), .q(q)
);

// File: tb/bidir_bus_reg_bench.sv
module bidir_bus_reg_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         a_en = 1'b0, dir_ab = 1'b0, par_mode = 1'b0, async_mode = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic         ser_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bidir_bus_reg #(.W(W)) u_bidir_bus_reg (
    .clk(clk), .rst_n(rst_n), .a_en(a_en), .dir_ab(dir_ab),
    .par_mode(par_mode), .async_mode(async_mode), .ser_in(ser_in),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in),
    .b_out(b_out), .b_oe(b_oe), .ser_out(ser_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edge_then_settle();
    @(posedge clk); #1;
  endtask

  task automatic to_negedge();
    @(negedge clk);
  endtask

  task automatic set_ctl(input logic en, input logic dir, input logic par, input logic asy);
    a_en = en; dir_ab = dir; par_mode = par; async_mode = asy;
  endtask

  task automatic t_reset();
    to_negedge();
    rst_n = 1'b0; set_ctl(0, 1, 1, 0); b_in = 8'hFF; a_in = 8'hFF;
    edge_then_settle();
    to_negedge(); rst_n = 1'b1; #1;
    chk("R1 word after reset", b_out, 8'h00);
    chk("R1 ser_out after reset", ser_out, 1'b0);
    chk("R3 b_oe dir=1", b_oe, 8'hFF);
    chk("R3 a_oe dir=1", a_oe, 8'h00);
  endtask

  task automatic t_sync_b_to_a();
    to_negedge(); set_ctl(1, 0, 1, 0); b_in = 8'hA5; #1;
    chk("R9 a_out before edge", a_out, 8'h00);
    chk("R3 a_oe en=1 dir=0", a_oe, 8'hFF);
    chk("R3 b_oe dir=0", b_oe, 8'h00);
    chk("R9 b_out undriven", b_out, 8'h00);
    edge_then_settle();
    chk("R5 a_out after edge", a_out, 8'hA5);
  endtask

  task automatic t_sync_a_to_b();
    to_negedge(); set_ctl(1, 1, 1, 0); a_in = 8'h3C; #1;
    chk("R9 b_out before edge", b_out, 8'hA5);
    edge_then_settle();
    chk("R6 b_out after edge", b_out, 8'h3C);
  endtask

  task automatic t_recirc();
    to_negedge(); set_ctl(0, 1, 1, 0); a_in = 8'hFF;
    edge_then_settle(); edge_then_settle();
    chk("R7 clocked recirc", b_out, 8'h3C);
    chk("R2 a_out locked", a_out, 8'h00);
    to_negedge(); async_mode = 1'b1; a_in = 8'h00; #1;
    chk("R7 async recirc no clock", b_out, 8'h3C);
    edge_then_settle();
    chk("R7 async recirc after edge", b_out, 8'h3C);
  endtask

  task automatic t_a_lockout();
    to_negedge(); set_ctl(0, 0, 1, 0); b_in = 8'h11; a_in = 8'hEE; #1;
    chk("R2 a_oe locked", a_oe, 8'h00);
    chk("R2 a_out locked", a_out, 8'h00);
    chk("R3 b_oe dir=0", b_oe, 8'h00);
    edge_then_settle();
    to_negedge(); set_ctl(0, 1, 1, 0); #1;
    chk("R5 word loaded from B while A locked", b_out, 8'h11);
  endtask

  task automatic t_serial();
    logic [W-1:0] exp;
    logic [7:0]   pat;
    exp = 8'h11; pat = 8'b0100_1101;
    to_negedge(); set_ctl(0, 1, 0, 1);
    for (int i = 0; i < 8; i++) begin
      ser_in = pat[i]; #1;
      chk("R4 no change between edges", b_out, exp);
      edge_then_settle();
      exp = {exp[W-2:0], pat[i]};
      chk("R4 shift result", b_out, exp);
      chk("R4 ser_out", ser_out, exp[W-1]);
      to_negedge();
    end
    set_ctl(1, 0, 0, 0); #1;
    chk("R9 serial word on A", a_out, exp);
    chk("R3 a_oe serial en=1 dir=0", a_oe, 8'hFF);
    set_ctl(0, 0, 0, 0); #1;
    chk("R3 no port driven", a_oe | b_oe, 8'h00);
  endtask

  task automatic t_async();
    to_negedge(); set_ctl(1, 1, 1, 1); a_in = 8'h5A; #1;
    chk("R8 b follows a_in without clock", b_out, 8'h5A);
    a_in = 8'h77; #1;
    chk("R8 b follows new a_in", b_out, 8'h77);
    edge_then_settle();
    to_negedge(); set_ctl(0, 1, 1, 0); a_in = 8'h00; #1;
    chk("R8 word kept after leaving mode", b_out, 8'h77);
    to_negedge(); set_ctl(1, 0, 1, 1); b_in = 8'h99; #1;
    chk("R8 a follows b_in without clock", a_out, 8'h99);
    edge_then_settle();
    to_negedge(); set_ctl(0, 1, 1, 0); #1;
    chk("R8 captured from B", b_out, 8'h99);
  endtask

  task automatic t_reset_midrun();
    to_negedge(); rst_n = 1'b0;
    edge_then_settle();
    to_negedge(); rst_n = 1'b1; #1;
    chk("R1 reset clears loaded word", b_out, 8'h00);
  endtask

  initial begin
    t_reset();
    t_sync_b_to_a();
    t_sync_a_to_b();
    t_recirc();
    t_a_lockout();
    t_serial();
    t_async();
    t_reset_midrun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule